// File: doc/BRIEF.md
# Variable-Length Radix-2 FFT Sequencer

This block steps an in-place, decimation-in-time radix-2 FFT through its stages and butterflies. It drives a datapath and memory that sit outside it. One start pulse launches a transform of 128, 256, 512 or 1024 points. The size and the 8-bit or 16-bit precision are captured on that pulse. For every butterfly the block then issues a pair of read addresses, the twiddle index and a valid strobe. After a fixed datapath latency it issues the matching write addresses. A stage only starts once the write-backs of the previous stage are complete. A single-cycle done pulse closes the run.

Input samples are expected in bit-reversed order before the run starts. A combinational load port maps a natural-order sample index to its bit-reversed storage address for the length currently selected. All addresses are 10 bits wide and are zero above the selected length's width. The low 7 bits of an address therefore select a word inside a 128-word, 16-bit bank, or the low 8 bits select a word inside a 256-word bank. The remaining high bits select the bank.

Top module: `fft_ctl`

## Requirements
- R1: After reset, busy, done, bfly_valid and wr_valid are all 0.
- R2: A start pulse while idle captures len_sel, where code c selects N = 2^(7+c). In the next cycle busy is 1, bfly_valid is 1, stage_num is 0 and bfly_num is 0. The run then has log2(N) stages, numbered 0 to log2(N)-1.
- R3: Each stage issues N/2 butterflies on consecutive cycles with bfly_valid high, and bfly_num counts 0 to N/2-1. The stages run in increasing order.
- R4: For stage s and butterfly k, rd_addr_a is k with a 0 inserted at bit position s. rd_addr_b is rd_addr_a XOR 2^s. Both addresses are below N.
- R5: twiddle_idx equals (rd_addr_a mod 2^s) multiplied by N/2^(s+1).
- R6: wr_addr_a and wr_addr_b repeat each read address pair exactly PIPE_LAT (default 3) cycles after it is issued. wr_valid is high in exactly those cycles.
- R7: After the last butterfly of every stage, bfly_valid stays low for exactly PIPE_LAT cycles before the next stage begins.
- R8: done is high for exactly one cycle. That cycle is the one after the last write of the final stage. busy is high during it and low in the next cycle.
- R9: A start pulse while busy has no effect. A change of len_sel or prec_sel while busy also has no effect. The running address sequence, stage count and precision output continue unchanged.
- R10: prec_8b takes the prec_sel value captured at start (1 = 8-bit, 0 = 16-bit) and holds it for the whole run.
- R11: load_addr is the bit reversal of the low log2(N) bits of load_idx, with N taken from the current len_sel. The bits of load_idx above that width are ignored, and the bits of load_addr above it are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| len_sel | input | 2 | Length code, N = 2^(7+code) |
| prec_sel | input | 1 | 1 selects 8-bit precision, 0 selects 16-bit |
| load_idx | input | 10 | Natural-order sample index for loading |
| load_addr | output | 10 | Bit-reversed storage address of load_idx |
| rd_addr_a | output | 10 | Upper butterfly read address |
| rd_addr_b | output | 10 | Lower (partner) butterfly read address |
| twiddle_idx | output | 9 | Twiddle factor index |
| bfly_valid | output | 1 | Read pair and twiddle valid |
| wr_addr_a | output | 10 | Upper write-back address |
| wr_addr_b | output | 10 | Lower write-back address |
| wr_valid | output | 1 | Write pair valid |
| stage_num | output | 4 | Current stage |
| bfly_num | output | 9 | Butterfly counter within the stage |
| prec_8b | output | 1 | Captured precision mode for the multiplier |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the stage boundaries. There the write pipe is still emptying, no new reads may start, and the partner stride doubles. The final boundary also has to produce the done pulse. The stimulus runs a full transform for every one of the four lengths, so each boundary is crossed for every size. A start pulse with a different length and precision is injected in the middle of a stage to show the sequence does not change. The load mapping is swept over all 1024 indices at all four lengths.

// File: rtl/fft_ctl_pkg.sv
package fft_ctl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_FIN   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/fft_ctl_seq.sv
module fft_ctl_seq
   import fft_ctl_pkg::*;
#(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 7,
   parameter int LSEL_W   = 2,
   parameter int PIPE_LAT = 3,
   localparam int STG_W   = $clog2(MAX_LOG2 + 1),
   localparam int HALF_W  = MAX_LOG2 - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LSEL_W-1:0] len_sel,
   input  logic              prec_sel,
   output seq_state_e        state,
   output logic [STG_W-1:0]  stage,
   output logic [HALF_W-1:0] bfly,
   output logic [STG_W-1:0]  log2n,
   output logic              prec
);
   localparam int LAT_W = (PIPE_LAT < 2) ? 1 : $clog2(PIPE_LAT);

   seq_state_e        st_q;
   logic [STG_W-1:0]  stage_q;
   logic [HALF_W-1:0] k_q;
   logic [STG_W-1:0]  log2n_q;
   logic              prec_q;
   logic [LAT_W-1:0]  dcnt_q;

   logic [HALF_W-1:0] k_lim;
   logic              k_last;
   logic              stage_last;
   logic              drain_end;

   always_comb begin
      k_lim      = ~({HALF_W{1'b1}} << (log2n_q - STG_W'(1)));
      k_last     = (k_q == k_lim);
      stage_last = (stage_q == (log2n_q - STG_W'(1)));
      drain_end  = (dcnt_q == LAT_W'(PIPE_LAT - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         stage_q <= '0;
         k_q     <= '0;
         log2n_q <= STG_W'(MIN_LOG2);
         prec_q  <= 1'b0;
         dcnt_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  log2n_q <= STG_W'(MIN_LOG2) + STG_W'(len_sel);
                  prec_q  <= prec_sel;
                  stage_q <= '0;
                  k_q     <= '0;
                  st_q    <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (k_last) begin
                  dcnt_q <= '0;
                  st_q   <= ST_DRAIN;
               end else begin
                  k_q <= k_q + HALF_W'(1);
               end
            end
            ST_DRAIN: begin
               if (drain_end) begin
                  if (stage_last) begin
                     st_q <= ST_FIN;
                  end else begin
                     stage_q <= stage_q + STG_W'(1);
                     k_q     <= '0;
                     st_q    <= ST_RUN;
                  end
               end else begin
                  dcnt_q <= dcnt_q + LAT_W'(1);
               end
            end
            ST_FIN: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign state = st_q;
   assign stage = stage_q;
   assign bfly  = k_q;
   assign log2n = log2n_q;
   assign prec  = prec_q;
endmodule

// File: rtl/fft_ctl_agen.sv
module fft_ctl_agen #(
   parameter int MAX_LOG2 = 10,
   localparam int STG_W   = $clog2(MAX_LOG2 + 1),
   localparam int HALF_W  = MAX_LOG2 - 1
) (
   input  logic [STG_W-1:0]    stage,
   input  logic [STG_W-1:0]    log2n,
   input  logic [HALF_W-1:0]   bfly,
   output logic [MAX_LOG2-1:0] addr_a,
   output logic [MAX_LOG2-1:0] addr_b,
   output logic [HALF_W-1:0]   twiddle
);
   logic [MAX_LOG2-1:0] k_ext;
   logic [MAX_LOG2-1:0] spread;
   logic [MAX_LOG2-1:0] part_bit;
   logic [MAX_LOG2-1:0] len_mask;
   logic [HALF_W-1:0]   low_bits;
   logic [STG_W-1:0]    tw_shift;

   assign k_ext = {1'b0, bfly};

   // Each address bit takes the counter bit at or one below its position,
   // with a zero opened at the stage position.
   for (genvar b = 0; b < MAX_LOG2; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign spread[b] = (stage > STG_W'(b)) ? k_ext[b] : 1'b0;
      end else begin : g_up
         assign spread[b] = (stage > STG_W'(b))  ? k_ext[b]   :
                            (stage == STG_W'(b)) ? 1'b0       : k_ext[b-1];
      end
   end

   always_comb begin
      part_bit = MAX_LOG2'(1) << stage;
      len_mask = ~({MAX_LOG2{1'b1}} << log2n);
      addr_a   = spread & len_mask;
      addr_b   = (spread ^ part_bit) & len_mask;
      low_bits = addr_a[HALF_W-1:0] & (part_bit[HALF_W-1:0] - HALF_W'(1));
      tw_shift = log2n - STG_W'(1) - stage;
      twiddle  = low_bits << tw_shift;
   end
endmodule

// File: rtl/fft_ctl_wpipe.sv
module fft_ctl_wpipe #(
   parameter int W     = 20,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic         v_q [DEPTH];
   logic [W-1:0] d_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      logic         v_in;
      logic [W-1:0] d_in;
      if (i == 0) begin : g_head
         assign v_in = in_valid;
         assign d_in = in_data;
      end else begin : g_body
         assign v_in = v_q[i-1];
         assign d_in = d_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
         end else begin
            v_q[i] <= v_in;
            d_q[i] <= d_in;
         end
      end
   end

   assign out_valid = v_q[DEPTH-1];
   assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/fft_ctl_bitrev.sv
module fft_ctl_bitrev #(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 7,
   parameter int LSEL_W   = 2,
   localparam int STG_W   = $clog2(MAX_LOG2 + 1)
) (
   input  logic [LSEL_W-1:0]   len_sel,
   input  logic [MAX_LOG2-1:0] idx,
   output logic [MAX_LOG2-1:0] addr
);
   logic [STG_W-1:0]    nbits;
   logic [STG_W-1:0]    gap;
   logic [MAX_LOG2-1:0] kept;
   logic [MAX_LOG2-1:0] rev;

   always_comb begin
      nbits = STG_W'(MIN_LOG2) + STG_W'(len_sel);
      gap   = STG_W'(MAX_LOG2) - nbits;
      kept  = idx & ~({MAX_LOG2{1'b1}} << nbits);
   end

   for (genvar b = 0; b < MAX_LOG2; b++) begin : g_rev
      assign rev[b] = kept[MAX_LOG2-1-b];
   end

   assign addr = rev >> gap;
endmodule

// File: rtl/fft_ctl.sv
module fft_ctl
   import fft_ctl_pkg::*;
#(
   parameter int MAX_LOG2 = 10,
   parameter int MIN_LOG2 = 7,
   parameter int LSEL_W   = 2,
   parameter int PIPE_LAT = 3,
   localparam int ADDR_W  = MAX_LOG2,
   localparam int HALF_W  = MAX_LOG2 - 1,
   localparam int STG_W   = $clog2(MAX_LOG2 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LSEL_W-1:0] len_sel,
   input  logic              prec_sel,
   input  logic [ADDR_W-1:0] load_idx,
   output logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] rd_addr_a,
   output logic [ADDR_W-1:0] rd_addr_b,
   output logic [HALF_W-1:0] twiddle_idx,
   output logic              bfly_valid,
   output logic [ADDR_W-1:0] wr_addr_a,
   output logic [ADDR_W-1:0] wr_addr_b,
   output logic              wr_valid,
   output logic [STG_W-1:0]  stage_num,
   output logic [HALF_W-1:0] bfly_num,
   output logic              prec_8b,
   output logic              busy,
   output logic              done
);
   if (MAX_LOG2 - MIN_LOG2 + 1 != (1 << LSEL_W)) begin : g_bad_range
      $error("length select width does not cover the length range");
   end
   if (PIPE_LAT < 1) begin : g_bad_lat
      $error("datapath latency must be at least one cycle");
   end
   if (MIN_LOG2 < 2) begin : g_bad_min
      $error("shortest transform must have at least two stages");
   end

   seq_state_e       state;
   logic [STG_W-1:0] log2n;
   logic [2*ADDR_W-1:0] wdata;

   fft_ctl_seq #(
      .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2),
      .LSEL_W(LSEL_W), .PIPE_LAT(PIPE_LAT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
      .prec_sel(prec_sel), .state(state), .stage(stage_num),
      .bfly(bfly_num), .log2n(log2n), .prec(prec_8b)
   );

   fft_ctl_agen #(.MAX_LOG2(MAX_LOG2)) u_agen (
      .stage(stage_num), .log2n(log2n), .bfly(bfly_num),
      .addr_a(rd_addr_a), .addr_b(rd_addr_b), .twiddle(twiddle_idx)
   );

   fft_ctl_wpipe #(.W(2*ADDR_W), .DEPTH(PIPE_LAT)) u_wpipe (
      .clk(clk), .rst_n(rst_n), .in_valid(bfly_valid),
      .in_data({rd_addr_a, rd_addr_b}),
      .out_valid(wr_valid), .out_data(wdata)
   );

   fft_ctl_bitrev #(
      .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2), .LSEL_W(LSEL_W)
   ) u_bitrev (
      .len_sel(len_sel), .idx(load_idx), .addr(load_addr)
   );

   assign wr_addr_a  = wdata[2*ADDR_W-1:ADDR_W];
   assign wr_addr_b  = wdata[ADDR_W-1:0];
   assign bfly_valid = (state == ST_RUN);
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_FIN);
endmodule

// File: rtl/fft_ctl_chk.sv
module fft_ctl_chk #(
   parameter int ADDR_W = 10,
   parameter int HALF_W = 9,
   parameter int STG_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              bfly_valid,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [ADDR_W-1:0] wr_addr_a,
   input logic [ADDR_W-1:0] wr_addr_b,
   input logic [STG_W-1:0]  stage_num,
   input logic [HALF_W-1:0] bfly_num,
   input logic              prec_8b
);
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && bfly_valid && stage_num == '0 && bfly_num == '0));

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bfly_valid && $past(bfly_valid)) |-> (bfly_num == $past(bfly_num) + HALF_W'(1)));

   assert_rd_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bfly_valid |-> ($countones(rd_addr_a ^ rd_addr_b) == 1 &&
                      (rd_addr_a & (rd_addr_a ^ rd_addr_b)) == '0));

   assert_wr_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_addr_a ^ wr_addr_b) == 1));

   assert_done_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && !bfly_valid && !wr_valid));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_prec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(prec_8b));
endmodule

bind fft_ctl fft_ctl_chk #(
   .ADDR_W(ADDR_W), .HALF_W(HALF_W), .STG_W(STG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .bfly_valid(bfly_valid), .wr_valid(wr_valid),
   .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
   .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
   .stage_num(stage_num), .bfly_num(bfly_num), .prec_8b(prec_8b)
);

// File: tb/fft_ctl_test.sv
module fft_ctl_test;
   localparam int LAT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] len_sel = 2'd0;
   logic       prec_sel = 1'b0;
   logic [9:0] load_idx = '0;
   logic [9:0] load_addr, rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
   logic [8:0] twiddle_idx, bfly_num;
   logic [3:0] stage_num;
   logic       bfly_valid, wr_valid, prec_8b, busy, done;

   int checks = 0;
   int errors = 0;
   int cyc;
   int ring_v [8];
   int ring_a [8];
   int ring_b [8];

   always #4 clk = ~clk;

   fft_ctl #(.PIPE_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
      .prec_sel(prec_sel), .load_idx(load_idx), .load_addr(load_addr),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .twiddle_idx(twiddle_idx), .bfly_valid(bfly_valid),
      .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b), .wr_valid(wr_valid),
      .stage_num(stage_num), .bfly_num(bfly_num), .prec_8b(prec_8b),
      .busy(busy), .done(done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
      end
   endtask

   // write side: pair issued LAT cycles earlier (R6)
   task automatic chk_wr();
      int slot;
      if (cyc >= LAT) begin
         slot = (cyc - LAT) % 8;
         chk("R6 wr_valid", int'(wr_valid), ring_v[slot]);
         if (ring_v[slot] != 0) begin
            chk("R6 wr_addr_a", int'(wr_addr_a), ring_a[slot]);
            chk("R6 wr_addr_b", int'(wr_addr_b), ring_b[slot]);
         end
      end else begin
         chk("R6 wr_valid early", int'(wr_valid), 0);
      end
   endtask

   task automatic push(input int v, input int a, input int b);
      ring_v[cyc % 8] = v;
      ring_a[cyc % 8] = a;
      ring_b[cyc % 8] = b;
      @(negedge clk);
      cyc++;
   endtask

   task automatic run(input int lsel, input int prec, input bit inject);
      int nl, n;
      nl = 7 + lsel;
      n  = 1 << nl;
      len_sel  = 2'(lsel);
      prec_sel = 1'(prec);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      len_sel  = 2'(3 - lsel);
      prec_sel = 1'(1 - prec);
      cyc = 0;
      for (int s = 0; s < nl; s++) begin
         for (int k = 0; k < n / 2; k++) begin
            int lowm, a, b, tw;
            lowm = k & ((1 << s) - 1);
            a  = ((k >> s) << (s + 1)) | lowm;
            b  = a ^ (1 << s);
            tw = lowm << (nl - 1 - s);
            if (s == 0 && k == 0) begin
               chk("R2 busy after start", int'(busy), 1);
            end
            chk("R3 bfly_valid", int'(bfly_valid), 1);
            chk("R3 stage_num", int'(stage_num), s);
            chk("R3 bfly_num", int'(bfly_num), k);
            chk("R4 rd_addr_a", int'(rd_addr_a), a);
            chk("R4 rd_addr_b", int'(rd_addr_b), b);
            chk("R5 twiddle_idx", int'(twiddle_idx), tw);
            chk("R8 done low in run", int'(done), 0);
            chk("R10 prec_8b held", int'(prec_8b), prec);
            chk_wr();
            // R9: busy-time start with other settings
            start = (inject && s == 1 && k == 5) ? 1'b1 : 1'b0;
            push(1, a, b);
         end
         start = 1'b0;
         for (int d = 0; d < LAT; d++) begin
            chk("R7 bubble bfly_valid", int'(bfly_valid), 0);
            chk("R7 busy in bubble", int'(busy), 1);
            chk("R8 done low in bubble", int'(done), 0);
            chk_wr();
            push(0, 0, 0);
         end
      end
      chk("R8 done pulse", int'(done), 1);
      chk("R8 busy with done", int'(busy), 1);
      chk("R8 no write with done", int'(wr_valid), 0);
      chk("R9 no issue with done", int'(bfly_valid), 0);
      @(negedge clk);
      chk("R8 done single", int'(done), 0);
      chk("R8 idle after done", int'(busy), 0);
      chk("R10 prec kept after run", int'(prec_8b), prec);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 bfly_valid", int'(bfly_valid), 0);
      chk("R1 wr_valid", int'(wr_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", int'(busy), 0);

      // R11 load mapping sweep
      for (int ls = 0; ls < 4; ls++) begin
         for (int i = 0; i < 1024; i++) begin
            int nl, e;
            nl = 7 + ls;
            e = 0;
            for (int bt = 0; bt < nl; bt++)
               if (((i >> bt) & 1) != 0) e |= 1 << (nl - 1 - bt);
            len_sel  = 2'(ls);
            load_idx = 10'(i);
            #1;
            chk("R11 load_addr", int'(load_addr), e);
         end
      end

      @(negedge clk);
      run(0, 1, 1'b0);
      run(1, 0, 1'b1);
      run(2, 1, 1'b0);
      run(3, 0, 1'b1);
      run(0, 0, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule